// File: doc/BRIEF.md
# Transmit Handshake and Line Direction Controller

This block sits beside a UART transmitter and decides when the next character may start. A registered permit is re-evaluated only while the transmitter is idle. When automatic flow control is on, the permit also depends on one selected active-low handshake input, either the clear-to-send pin or the data-set-ready pin. A HIGH on the selected pin lets the character in flight finish and then blocks the next one. A LOW lets transmission carry on. Both handshake pins pass through a multi-flop synchronizer before they are used.

The block also drives the active-low RTS output. In half-duplex RS-485 mode this output serves as the enable for the transceiver's driver. It goes LOW (transmit) as soon as a character is queued. It stays LOW while characters follow one another. After the stop bit of the last character ends, it returns HIGH (receive) once a programmable number of bit times, from 0 to 15, has passed. With RS-485 mode off, the output is the inverse of a software RTS bit. The serializer and the baud generator are outside this block. It sees them only through a bit-time tick, a busy level and an end-of-character strobe.

Top module: `txflow_dir_ctrl`

## Requirements
- R1: After synchronous reset, `tx_permit` is 0 and `rts_n` is 1.
- R2: In a cycle where `tx_busy` is 0 and `fifo_empty` is 1, `tx_permit` is 0 after the next clock edge.
- R3: With `flow_en` = 0, the handshake pins have no effect: an idle transmitter with queued data gets `tx_permit` = 1 at the next edge, provided RS-485 mode is off.
- R4: With `flow_en` = 1, `flow_sel` = 0 watches `cts_n` and `flow_sel` = 1 watches `dsr_n`. A HIGH on the watched pin, once synchronized, blocks new characters, and a LOW allows them. The pin that is not selected is ignored. A pin change reaches `tx_permit` three edges later (two synchronizer flops plus the permit register).
- R5: `tx_permit` keeps its value on every edge at which `tx_busy` was 1, so a character that has started is never cut short.
- R6: With `rs485_en` = 0, `rts_n` equals the inverse of `rts_bit` from one cycle earlier.
- R7: With `rs485_en` = 1, `rts_n` goes to 0 (transmit) when data is queued, and `tx_permit` never rises unless `rts_n` is already 0. The transmitter therefore sees the driver enabled before the start bit. `rts_n` stays 0 through back-to-back characters.
- R8: With `rs485_en` = 1, `turn_dly` = N > 0 and the queue empty, `rts_n` returns to 1 on the edge that samples the N-th `bit_tick` after the `char_done` strobe. The strobe is expected on a tick cycle, marking the end of the last stop bit.
- R9: With `turn_dly` = 0, `rts_n` returns to 1 on the edge that samples `char_done`.
- R10: If a character is queued while the turnaround count is running, the count is dropped and `rts_n` stays 0. The full delay restarts from the next `char_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_busy | input | 1 | Transmitter is shifting a character |
| char_done | input | 1 | One-cycle strobe at the end of the last stop bit |
| fifo_empty | input | 1 | Transmit queue holds no character |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| flow_en | input | 1 | Automatic hardware flow control enable |
| flow_sel | input | 1 | 0 watches cts_n, 1 watches dsr_n |
| rs485_en | input | 1 | RTS drives the transceiver direction |
| turn_dly | input | DLY_W | Turnaround delay in bit times (0 to 15 by default) |
| rts_bit | input | 1 | Software RTS level used when RS-485 mode is off |
| tx_permit | output | 1 | Transmitter may start a new character |
| rts_n | output | 1 | Active-low RTS / driver enable |

## Verification
The permit is tried with flow control off while the pins are high, with each pin selected in turn while the other pin toggles, and with the watched pin raised in the middle of a character. These cases separate ignoring the pins, watching the wrong pin, and gating in mid-character. The direction output is tried with two characters sent back to back, with delays of 3 and 0, and with a second character queued in the middle of a countdown. Counting bit ticks from the end-of-character strobe to the rising edge of RTS separates an off-by-one delay, a delay of zero that still waits, and a countdown that is not cancelled.

// File: rtl/txflow_pkg.sv
package txflow_pkg;
  localparam int FC_PINS = 2;
  typedef enum logic {FC_CTS = 1'b0, FC_DSR = 1'b1} fc_sel_e;
endpackage

// File: rtl/txf_sync.sv
module txf_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/txf_flow_gate.sv
module txf_flow_gate
  import txflow_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               flow_en,
  input  logic               flow_sel,
  input  logic [FC_PINS-1:0] fc_sync,
  input  logic               fifo_empty,
  input  logic               tx_busy,
  input  logic               dir_ok,
  output logic               tx_permit
);
  logic watched_hi;
  logic flow_ok;

  always_comb begin
    watched_hi = (fc_sel_e'(flow_sel) == FC_DSR) ? fc_sync[1] : fc_sync[0];
    flow_ok    = !flow_en || !watched_hi;
  end

  // permit only changes at character boundaries (transmitter idle)
  always_ff @(posedge clk) begin
    if (rst)           tx_permit <= 1'b0;
    else if (!tx_busy) tx_permit <= !fifo_empty && flow_ok && dir_ok;
  end
endmodule

// File: rtl/txf_dir_timer.sv
module txf_dir_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             char_done,
  input  logic             pending,
  input  logic [DLY_W-1:0] dly,
  output logic             active,
  output logic             active_nxt
);
  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;

  always_comb begin
    active_nxt = active;
    cnt_n      = cnt_q;
    run_n      = run_q;
    if (pending) begin
      active_nxt = 1'b1;
      run_n      = 1'b0;
    end else if (char_done) begin
      if (dly == '0) active_nxt = 1'b0;
      else begin
        run_n = 1'b1;
        cnt_n = dly;
      end
    end else if (run_q && bit_tick) begin
      cnt_n = cnt_q - DLY_W'(1);
      if (cnt_q == DLY_W'(1)) begin
        active_nxt = 1'b0;
        run_n      = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      active <= active_nxt;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
    end
  end
endmodule

// File: rtl/txflow_dir_ctrl.sv
module txflow_dir_ctrl
  import txflow_pkg::*;
#(
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             tx_busy,
  input  logic             char_done,
  input  logic             fifo_empty,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             flow_en,
  input  logic             flow_sel,
  input  logic             rs485_en,
  input  logic [DLY_W-1:0] turn_dly,
  input  logic             rts_bit,
  output logic             tx_permit,
  output logic             rts_n
);
  logic [FC_PINS-1:0] fc_raw;
  logic [FC_PINS-1:0] fc_sync;
  logic               dir_active, dir_active_nxt;

  assign fc_raw = {dsr_n, cts_n};

  for (genvar g = 0; g < FC_PINS; g++) begin : g_sync
    txf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (fc_raw[g]),
      .q   (fc_sync[g])
    );
  end

  txf_dir_timer #(.DLY_W(DLY_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .char_done  (char_done),
    .pending    (!fifo_empty),
    .dly        (turn_dly),
    .active     (dir_active),
    .active_nxt (dir_active_nxt)
  );

  txf_flow_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .flow_en    (flow_en),
    .flow_sel   (flow_sel),
    .fc_sync    (fc_sync),
    .fifo_empty (fifo_empty),
    .tx_busy    (tx_busy),
    .dir_ok     (!rs485_en || dir_active),
    .tx_permit  (tx_permit)
  );

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b1;
    else     rts_n <= rs485_en ? !dir_active_nxt : !rts_bit;
  end
endmodule

// File: rtl/txf_checker.sv
module txf_checker (
  input logic clk,
  input logic rst,
  input logic tx_busy,
  input logic fifo_empty,
  input logic flow_en,
  input logic rs485_en,
  input logic rts_bit,
  input logic tx_permit,
  input logic rts_n
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!tx_permit && rts_n));

  assert_empty_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && !tx_busy) |=> !tx_permit);

  assert_flow_off_grants_R3: assert property (@(posedge clk) disable iff (rst)
    (!flow_en && !fifo_empty && !tx_busy && !rs485_en) |=> tx_permit);

  assert_hold_in_char_R5: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_permit));

  assert_rts_follows_bit_R6: assert property (@(posedge clk) disable iff (rst)
    !rs485_en |=> (rts_n == !$past(rts_bit)));

  assert_driver_before_permit_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_permit) && rs485_en && $past(rs485_en)) |-> !rts_n);
endmodule

bind txflow_dir_ctrl txf_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_busy    (tx_busy),
  .fifo_empty (fifo_empty),
  .flow_en    (flow_en),
  .rs485_en   (rs485_en),
  .rts_bit    (rts_bit),
  .tx_permit  (tx_permit),
  .rts_n      (rts_n)
);

// File: tb/tb_txflow_dir_ctrl.sv
module tb_txflow_dir_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 4;
  localparam int TICK_DIV   = 4;
  localparam int FRAME_BITS = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, tx_busy = 1'b0, char_done = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1;
  logic flow_en = 1'b0, flow_sel = 1'b0, rs485_en = 1'b0, rts_bit = 1'b0;
  logic [DLY_W-1:0] turn_dly = '0;
  logic fifo_empty;
  logic tx_permit, rts_n;

  int fifo_cnt = 0;
  assign fifo_empty = (fifo_cnt == 0);

  txflow_dir_ctrl #(.DLY_W(DLY_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .char_done(char_done), .fifo_empty(fifo_empty), .cts_n(cts_n),
    .dsr_n(dsr_n), .flow_en(flow_en), .flow_sel(flow_sel),
    .rs485_en(rs485_en), .turn_dly(turn_dly), .rts_bit(rts_bit),
    .tx_permit(tx_permit), .rts_n(rts_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int pipe_c[$], pipe_d[$];
  int m_permit = 0, m_rtsn = 1, m_active = 0, m_counting = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      pipe_c = '{1, 1};
      pipe_d = '{1, 1};
      m_permit = 0; m_rtsn = 1; m_active = 0; m_counting = 0; m_cnt = 0;
    end else begin
      int watched;
      int ok;
      int prev_active;
      watched     = flow_sel ? pipe_d[0] : pipe_c[0];
      ok          = (!flow_en || watched == 0) ? 1 : 0;
      prev_active = m_active;
      if (!fifo_empty) begin
        m_active = 1; m_counting = 0;
      end else if (char_done) begin
        if (turn_dly == 0) m_active = 0;
        else begin m_counting = 1; m_cnt = turn_dly; end
      end else if (m_counting == 1 && bit_tick) begin
        if (m_cnt == 1) begin m_active = 0; m_counting = 0; end
        m_cnt = m_cnt - 1;
      end
      if (!tx_busy) m_permit = (!fifo_empty && ok == 1 && (!rs485_en || prev_active == 1)) ? 1 : 0;
      m_rtsn = rs485_en ? (m_active == 1 ? 0 : 1) : (rts_bit ? 0 : 1);
      void'(pipe_c.pop_front()); pipe_c.push_back(int'(cts_n));
      void'(pipe_d.pop_front()); pipe_d.push_back(int'(dsr_n));
    end
  end

  // ------------- compare, tick source, transmitter stand-in, monitor -------------
  int div = 0, bits = 0, done_cnt = 0, since = 0, rise_n = 0, rise_ticks = -1;
  bit drop_pending = 1'b0;
  logic prev_rts = 1'b1;

  always @(negedge clk) begin
    cyc++;
    check(tx_permit === 1'(m_permit), cur_req, int'(tx_permit), m_permit, "tx_permit vs model");
    check(rts_n === 1'(m_rtsn), cur_req, int'(rts_n), m_rtsn, "rts_n vs model");
    if (char_done) since = 0;
    else if (bit_tick) since++;
    if (prev_rts === 1'b0 && rts_n === 1'b1) begin rise_n++; rise_ticks = since; end
    prev_rts = rts_n;
    div = (div + 1) % TICK_DIV;
    bit_tick = (div == 0);
    char_done = 1'b0;
    if (drop_pending) begin
      tx_busy = 1'b0; drop_pending = 1'b0;
    end else if (tx_busy) begin
      if (bit_tick) begin
        bits++;
        if (bits == FRAME_BITS) begin char_done = 1'b1; drop_pending = 1'b1; done_cnt++; end
      end
    end else if (!rst && tx_permit && !fifo_empty) begin
      if (rs485_en) check(rts_n === 1'b0, "R7", int'(rts_n), 0, "driver enabled at start");
      tx_busy = 1'b1; bits = 0; fifo_cnt--;
    end
  end

  always @(posedge clk) if (cyc > WATCHDOG) begin
    check(1'b0, "watchdog", cyc, WATCHDOG, "run exceeded cycle limit");
    finish_run();
  end

  task automatic wait_done(input int target, input string req);
    int n = 0;
    while (done_cnt < target && n < 3000) begin @(negedge clk); n++; end
    check(done_cnt >= target, req, done_cnt, target, "characters completed");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    int rises;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(tx_permit === 1'b0, "R1", int'(tx_permit), 0, "permit after reset");
    check(rts_n === 1'b1, "R1", int'(rts_n), 1, "rts_n after reset");

    cur_req = "R2"; idle(20);
    check(tx_permit === 1'b0 && tx_busy === 1'b0, "R2", int'(tx_permit), 0, "empty queue no permit");

    cur_req = "R3"; cts_n = 1'b1; dsr_n = 1'b1;
    fifo_cnt += 2; wait_done(2, "R3");

    cur_req = "R4"; flow_en = 1'b1; flow_sel = 1'b0; idle(5);
    base = done_cnt; fifo_cnt += 1; idle(40);
    check(done_cnt == base && tx_busy === 1'b0, "R4", done_cnt, base, "cts high blocks");
    dsr_n = 1'b0; idle(30);
    check(done_cnt == base, "R4", done_cnt, base, "dsr ignored when cts selected");
    cts_n = 1'b0; wait_done(base + 1, "R4");
    flow_sel = 1'b1; dsr_n = 1'b1; idle(5);
    base = done_cnt; fifo_cnt += 1; idle(40);
    check(done_cnt == base, "R4", done_cnt, base, "dsr high blocks");
    cts_n = 1'b1; idle(10); cts_n = 1'b0; idle(10);
    check(done_cnt == base, "R4", done_cnt, base, "cts ignored when dsr selected");
    dsr_n = 1'b0; wait_done(base + 1, "R4");

    cur_req = "R5"; flow_sel = 1'b0; idle(5);
    base = done_cnt; fifo_cnt += 2;
    while (!tx_busy) @(negedge clk);
    idle(8); cts_n = 1'b1;
    wait_done(base + 1, "R5");
    idle(40);
    check(done_cnt == base + 1 && fifo_cnt == 1, "R5", done_cnt, base + 1, "next char held after boundary");
    cts_n = 1'b0; wait_done(base + 2, "R5");
    flow_en = 1'b0;

    cur_req = "R6"; rts_bit = 1'b1; idle(2);
    check(rts_n === 1'b0, "R6", int'(rts_n), 0, "rts_n follows bit set");
    rts_bit = 1'b0; idle(2);
    check(rts_n === 1'b1, "R6", int'(rts_n), 1, "rts_n follows bit clear");

    cur_req = "R7"; turn_dly = 4'd3; rs485_en = 1'b1; idle(3);
    rises = rise_n; base = done_cnt; fifo_cnt += 2;
    wait_done(base + 2, "R7");
    check(rise_n == rises, "R7", rise_n, rises, "rts_n stays low between chars");
    cur_req = "R8"; idle(30);
    check(rise_n == rises + 1, "R8", rise_n, rises + 1, "single release");
    check(rise_ticks == 3, "R8", rise_ticks, 3, "release tick count");

    cur_req = "R9"; turn_dly = 4'd0; rises = rise_n; base = done_cnt;
    fifo_cnt += 1; wait_done(base + 1, "R9"); idle(10);
    check(rise_n == rises + 1 && rise_ticks == 0, "R9", rise_ticks, 0, "zero delay release");

    cur_req = "R10"; turn_dly = 4'd5; rises = rise_n; base = done_cnt;
    fifo_cnt += 1; wait_done(base + 1, "R10");
    idle(6); fifo_cnt += 1;
    wait_done(base + 2, "R10");
    check(rise_n == rises, "R10", rise_n, rises, "no release during restart");
    idle(40);
    check(rise_n == rises + 1 && rise_ticks == 5, "R10", rise_ticks, 5, "full delay after restart");

    finish_run();
  end
endmodule